// File: doc/BRIEF.md
# Four-Scale Gaussian and Difference-of-Gaussian Stage

This block turns a stream of 8-bit grayscale pixels into difference-of-Gaussian samples, the first step of scale-space keypoint detection. Pixels come in over a valid/ready handshake and go into a small input FIFO. The frame is delivered column by column: each column runs from the top row to the bottom row, and then the next column to the right begins. When a pixel is taken from the FIFO it is joined by the pixels at the same row in the four previous columns. This five-wide horizontal vector is passed to four smoothing filters at once, one filter per scale. Each filter is separable. It applies its fixed 5-tap kernel across the vector, keeps the last four horizontal results, and applies the same kernel down the column.

Each scale gives one smoothed value. Subtracting neighbouring scales (scale k+1 minus scale k) gives three signed DoG values. All three leave together in one output beat, with the position of the pixel that completed the 5x5 window and a flag that says whether the window lay wholly inside the frame. Every accepted pixel produces exactly one output beat. Backpressure on the output stalls the FIFO read side, and a start-of-frame marker on a pixel restarts the position counters.

Top module: `dog_stage`

## Requirements
- R1: After reset, and in the first cycle after any reset, `o_valid` is 0 and `i_ready` is 1.
- R2: A pixel is accepted in a cycle where `i_valid` and `i_ready` are both 1. While `o_ready` is held at 0 from an empty state, exactly FIFO_DEPTH+1 pixels are accepted before `i_ready` drops. FIFO_DEPTH is 8 by default, so the count is 9.
- R3: Pixels are in column-major order. With no start-of-frame marker, the k-th accepted pixel is at row k mod FRAME_H and column k div FRAME_H. After the last pixel (row FRAME_H-1, column FRAME_W-1) the position wraps to (0,0). `o_row`/`o_col` report the position of the pixel that completed the window.
- R4: A pixel presented with `i_sof`=1 takes position (0,0), and the pixels after it continue from there.
- R5: For a beat at (r,c) with `o_inside`=1, scale s gives g_s = (sum over i,j in 0..4 of K_s[i]*K_s[j]*P[r-4+i][c-4+j] + 128) >> 8. The default kernels are K_0={0,4,8,4,0}, K_1={1,4,6,4,1}, K_2={2,4,4,4,2} and K_3={3,3,4,3,3}. Each kernel sums to 2^SHIFT with SHIFT=4.
- R6: `o_dog0`, `o_dog1` and `o_dog2` are 10-bit two's-complement values equal to g_1-g_0, g_2-g_1 and g_3-g_2, so each lies in -255..255.
- R7: `o_inside` is 1 exactly when `o_row`>=4 and `o_col`>=4. When `o_inside` is 0, all three DoG outputs are 0.
- R8: While `o_valid`=1 and `o_ready`=0, `o_valid` stays 1 in the next cycle and the position and DoG outputs keep their values.
- R9: Output beats leave in the order the pixels were accepted, one per pixel. None is lost or repeated, and once the input stops the output goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Input pixel present |
| i_ready | output | 1 | Input FIFO has room |
| i_sof | input | 1 | This pixel starts a new frame |
| i_pix | input | 8 | Grayscale pixel |
| o_valid | output | 1 | Output beat present |
| o_ready | input | 1 | Downstream takes the beat |
| o_row | output | clog2(FRAME_H) | Row of the window's newest pixel |
| o_col | output | clog2(FRAME_W) | Column of the window's newest pixel |
| o_inside | output | 1 | The 5x5 window lies wholly inside the frame |
| o_dog0 | output | 10 | Scale 1 minus scale 0, signed |
| o_dog1 | output | 10 | Scale 2 minus scale 1, signed |
| o_dog2 | output | 10 | Scale 3 minus scale 2, signed |

## Verification
Two events can fall in the same cycle: the output register hands a beat downstream, and the FIFO pops the next pixel into that same register while a new pixel is pushed at the input. The bench provokes this with continuous input against `o_ready` patterns that alternate, skip every third cycle, or follow an irregular pattern. It judges the result by comparing every beat, in order, with a separable model of the frame. A separate case holds `o_ready` low at the start to measure the exact FIFO capacity and to see the held beat stay unchanged.

// File: rtl/dog_stage_pkg.sv
package dog_stage_pkg;

    localparam int PIX_W      = 8;
    localparam int TAPS       = 5;
    localparam int HIST       = TAPS - 1;
    localparam int COEF_W     = 5;
    localparam int NUM_SCALES = 4;
    localparam int NUM_DOG    = NUM_SCALES - 1;
    localparam int DOG_W      = 10;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic [COEF_W-1:0]       coef_t;
    typedef coef_t [TAPS-1:0]        kernel_t;
    typedef pix_t  [TAPS-1:0]        tapvec_t;
    typedef logic signed [DOG_W-1:0] dog_t;

    typedef struct packed {
        logic sof;
        pix_t pix;
    } in_beat_t;

    // Signed difference of two smoothed scales, widened so negatives survive.
    function automatic dog_t scale_diff(input pix_t upper, input pix_t lower);
        dog_t a;
        dog_t b;
        a = $signed({{(DOG_W-PIX_W){1'b0}}, upper});
        b = $signed({{(DOG_W-PIX_W){1'b0}}, lower});
        return a - b;
    endfunction

endpackage

// File: rtl/dog_input_fifo.sv
module dog_input_fifo
    import dog_stage_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_valid,
    output logic     wr_ready,
    input  in_beat_t wr_data,
    input  logic     rd_en,
    output logic     rd_avail,
    output in_beat_t rd_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    in_beat_t           mem [DEPTH];
    logic [PTR_W-1:0]   wptr;
    logic [PTR_W-1:0]   rptr;
    logic [CNT_W-1:0]   count;
    logic               push;
    logic               pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_ready = (count != CNT_W'(DEPTH));
    assign rd_avail = (count != '0);
    assign push     = wr_valid && wr_ready;
    assign pop      = rd_en && rd_avail;
    assign rd_data  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

endmodule

// File: rtl/dog_column_window.sv
module dog_column_window
    import dog_stage_pkg::*;
#(
    parameter int FRAME_W = 320,
    parameter int FRAME_H = 240,
    localparam int ROW_W  = $clog2(FRAME_H),
    localparam int COL_W  = $clog2(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             sof,
    input  pix_t             pix,
    output tapvec_t          taps,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);

    // line[k][y] holds the pixel at row y of column (current - 1 - k)
    pix_t             line [HIST][FRAME_H];
    logic [ROW_W-1:0] nxt_row;
    logic [COL_W-1:0] nxt_col;

    assign row = sof ? '0 : nxt_row;
    assign col = sof ? '0 : nxt_col;

    assign taps[TAPS-1] = pix;

    for (genvar k = 0; k < HIST; k++) begin : g_col
        assign taps[HIST-1-k] = line[k][row];
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (step) line[0][row] <= pix;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (step) line[k][row] <= line[k-1][row];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_row <= '0;
            nxt_col <= '0;
        end else if (step) begin
            if (row == ROW_W'(FRAME_H - 1)) begin
                nxt_row <= '0;
                nxt_col <= (col == COL_W'(FRAME_W - 1)) ? '0 : col + 1'b1;
            end else begin
                nxt_row <= row + 1'b1;
                nxt_col <= col;
            end
        end
    end

endmodule

// File: rtl/dog_scale_filter.sv
module dog_scale_filter
    import dog_stage_pkg::*;
#(
    parameter kernel_t KERN  = {5'd1, 5'd4, 5'd6, 5'd4, 5'd1},
    parameter int      SHIFT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  tapvec_t taps,
    output pix_t    smooth
);

    localparam int HW = PIX_W + SHIFT + 1;
    localparam int VW = HW + SHIFT + 1;

    logic [HW-1:0] hsum;
    logic [HW-1:0] hist [HIST];
    logic [VW-1:0] vsum;
    logic [VW-1:0] vround;
    logic [VW-1:0] vshift;

    // Horizontal pass across the five columns of the current row.
    always_comb begin
        hsum = '0;
        for (int j = 0; j < TAPS; j++) begin
            hsum = hsum + HW'(KERN[j]) * HW'(taps[j]);
        end
    end

    // Vertical pass: newest row takes the last tap, hist[i] is i+1 rows up.
    always_comb begin
        vsum = VW'(KERN[TAPS-1]) * VW'(hsum);
        for (int i = 0; i < HIST; i++) begin
            vsum = vsum + VW'(KERN[HIST-1-i]) * VW'(hist[i]);
        end
        vround = vsum + (VW'(1) << (2 * SHIFT - 1));
        vshift = vround >> (2 * SHIFT);
        smooth = (|vshift[VW-1:PIX_W]) ? '1 : vshift[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HIST; i++) hist[i] <= '0;
        end else if (step) begin
            hist[0] <= hsum;
            for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        end
    end

endmodule

// File: rtl/dog_stage.sv
module dog_stage
    import dog_stage_pkg::*;
#(
    parameter int      FRAME_W    = 320,
    parameter int      FRAME_H    = 240,
    parameter int      FIFO_DEPTH = 8,
    parameter int      SHIFT      = 4,
    parameter kernel_t KERN_S0    = {5'd0, 5'd4, 5'd8, 5'd4, 5'd0},
    parameter kernel_t KERN_S1    = {5'd1, 5'd4, 5'd6, 5'd4, 5'd1},
    parameter kernel_t KERN_S2    = {5'd2, 5'd4, 5'd4, 5'd4, 5'd2},
    parameter kernel_t KERN_S3    = {5'd3, 5'd3, 5'd4, 5'd3, 5'd3},
    localparam int     ROW_W      = $clog2(FRAME_H),
    localparam int     COL_W      = $clog2(FRAME_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_valid,
    output logic                    i_ready,
    input  logic                    i_sof,
    input  logic [PIX_W-1:0]        i_pix,
    output logic                    o_valid,
    input  logic                    o_ready,
    output logic [ROW_W-1:0]        o_row,
    output logic [COL_W-1:0]        o_col,
    output logic                    o_inside,
    output logic signed [DOG_W-1:0] o_dog0,
    output logic signed [DOG_W-1:0] o_dog1,
    output logic signed [DOG_W-1:0] o_dog2
);

    localparam kernel_t KERNS [NUM_SCALES] = '{KERN_S0, KERN_S1, KERN_S2, KERN_S3};

    in_beat_t         fifo_out;
    logic             fifo_avail;
    logic             pop;
    tapvec_t          taps;
    logic [ROW_W-1:0] win_row;
    logic [COL_W-1:0] win_col;
    logic             win_inside;
    pix_t             smooth [NUM_SCALES];
    dog_t             dog_c  [NUM_DOG];
    dog_t             dog_q  [NUM_DOG];

    // The output register frees up when it is empty or being drained.
    assign pop = fifo_avail && (!o_valid || o_ready);

    dog_input_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (i_valid),
        .wr_ready (i_ready),
        .wr_data  ('{sof: i_sof, pix: i_pix}),
        .rd_en    (pop),
        .rd_avail (fifo_avail),
        .rd_data  (fifo_out)
    );

    dog_column_window #(
        .FRAME_W (FRAME_W),
        .FRAME_H (FRAME_H)
    ) u_window (
        .clk  (clk),
        .rst  (rst),
        .step (pop),
        .sof  (fifo_out.sof),
        .pix  (fifo_out.pix),
        .taps (taps),
        .row  (win_row),
        .col  (win_col)
    );

    for (genvar s = 0; s < NUM_SCALES; s++) begin : g_scale
        dog_scale_filter #(
            .KERN  (KERNS[s]),
            .SHIFT (SHIFT)
        ) u_filter (
            .clk    (clk),
            .rst    (rst),
            .step   (pop),
            .taps   (taps),
            .smooth (smooth[s])
        );
    end

    for (genvar d = 0; d < NUM_DOG; d++) begin : g_dog
        assign dog_c[d] = scale_diff(smooth[d+1], smooth[d]);
    end

    assign win_inside = (win_row >= ROW_W'(HIST)) && (win_col >= COL_W'(HIST));

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_row    <= '0;
            o_col    <= '0;
            o_inside <= 1'b0;
            for (int d = 0; d < NUM_DOG; d++) dog_q[d] <= '0;
        end else if (pop) begin
            o_valid  <= 1'b1;
            o_row    <= win_row;
            o_col    <= win_col;
            o_inside <= win_inside;
            for (int d = 0; d < NUM_DOG; d++) dog_q[d] <= win_inside ? dog_c[d] : '0;
        end else if (o_ready) begin
            o_valid  <= 1'b0;
        end
    end

    assign o_dog0 = dog_q[0];
    assign o_dog1 = dog_q[1];
    assign o_dog2 = dog_q[2];

endmodule

// File: rtl/dog_stage_checker.sv
module dog_stage_checker
    import dog_stage_pkg::*;
#(
    parameter int  FRAME_W = 320,
    parameter int  FRAME_H = 240,
    localparam int ROW_W   = $clog2(FRAME_H),
    localparam int COL_W   = $clog2(FRAME_W)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    i_ready,
    input logic                    o_valid,
    input logic                    o_ready,
    input logic [ROW_W-1:0]        o_row,
    input logic [COL_W-1:0]        o_col,
    input logic                    o_inside,
    input logic signed [DOG_W-1:0] o_dog0,
    input logic signed [DOG_W-1:0] o_dog1,
    input logic signed [DOG_W-1:0] o_dog2
);

    logic             have_last;
    logic [ROW_W-1:0] last_row;
    logic [COL_W-1:0] last_col;
    logic [ROW_W-1:0] succ_row;
    logic [COL_W-1:0] succ_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_last <= 1'b0;
            last_row  <= '0;
            last_col  <= '0;
        end else if (o_valid && o_ready) begin
            have_last <= 1'b1;
            last_row  <= o_row;
            last_col  <= o_col;
        end
    end

    always_comb begin
        if (last_row == ROW_W'(FRAME_H - 1)) begin
            succ_row = '0;
            succ_col = (last_col == COL_W'(FRAME_W - 1)) ? '0 : last_col + 1'b1;
        end else begin
            succ_row = last_row + 1'b1;
            succ_col = last_col;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!o_valid && i_ready));

    a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_row) && $stable(o_col)
            && $stable(o_dog0) && $stable(o_dog1) && $stable(o_dog2)));

    a_r7_border_zero: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_inside) |-> (o_dog0 == '0 && o_dog1 == '0 && o_dog2 == '0));

    a_r6_dog_range: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_dog0 >= -10'sd255 && o_dog0 <= 10'sd255
                  && o_dog1 >= -10'sd255 && o_dog1 <= 10'sd255
                  && o_dog2 >= -10'sd255 && o_dog2 <= 10'sd255));

    a_r3_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_row <= ROW_W'(FRAME_H - 1) && o_col <= COL_W'(FRAME_W - 1)));

    // R9 order, R4 restart: each handed-off beat follows the previous or restarts at origin
    a_r9_beat_order: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_ready && have_last) |->
            ((o_row == succ_row && o_col == succ_col) || (o_row == '0 && o_col == '0)));

endmodule

bind dog_stage dog_stage_checker #(
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H)
) u_dog_chk (
    .clk      (clk),
    .rst      (rst),
    .i_ready  (i_ready),
    .o_valid  (o_valid),
    .o_ready  (o_ready),
    .o_row    (o_row),
    .o_col    (o_col),
    .o_inside (o_inside),
    .o_dog0   (o_dog0),
    .o_dog1   (o_dog1),
    .o_dog2   (o_dog2)
);

// File: tb/dog_stage_bench.sv
`timescale 1ns/1ps
module dog_stage_bench;

    localparam int W     = 8;
    localparam int H     = 7;
    localparam int DEPTH = 8;
    localparam int NPIX  = W * H;
    localparam int RW    = $clog2(H);
    localparam int CW    = $clog2(W);

    // kernels from R5
    localparam int BK [4][5] = '{'{0,4,8,4,0}, '{1,4,6,4,1}, '{2,4,4,4,2}, '{3,3,4,3,3}};

    // kind, seed, ready mode, sof on first pixel
    localparam int CASES [6][4] = '{
        '{0,   3, 0, 1},
        '{3,  91, 1, 0},
        '{1,   0, 4, 1},
        '{2, 200, 2, 0},
        '{3,   7, 3, 1},
        '{1,   1, 1, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i_valid = 1'b0;
    logic i_ready;
    logic i_sof = 1'b0;
    logic [7:0] i_pix = '0;
    logic o_valid;
    logic o_ready = 1'b0;
    logic [RW-1:0] o_row;
    logic [CW-1:0] o_col;
    logic o_inside;
    logic signed [9:0] o_dog0, o_dog1, o_dog2;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int frame [H][W];

    always #2 clk = ~clk;

    dog_stage #(.FRAME_W(W), .FRAME_H(H), .FIFO_DEPTH(DEPTH)) u_dog_stage (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_ready(i_ready), .i_sof(i_sof),
        .i_pix(i_pix), .o_valid(o_valid), .o_ready(o_ready), .o_row(o_row),
        .o_col(o_col), .o_inside(o_inside), .o_dog0(o_dog0), .o_dog1(o_dog1),
        .o_dog2(o_dog2)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                finish_run();
            end
        end
    end

    function automatic int pix_at(int kind, int seed, int r, int c);
        case (kind)
            0: return (r * 29 + c * 13 + seed) & 255;
            1: return ((r + c) % 2 == 1) ? 255 : 0;
            2: return (r == 4 && c == 5) ? 255 : (seed & 15);
            default: return ((r * 131 + c * 71 + seed * 17) ^ (r * c * 5)) & 255;
        endcase
    endfunction

    function automatic int gauss(int s, int r, int c);
        int acc = 0;
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                acc += BK[s][i] * BK[s][j] * frame[r-4+i][c-4+j];
        return (acc + 128) >> 8;
    endfunction

    function automatic bit ready_at(int mode, int cyc);
        case (mode)
            1: return (cyc % 2) == 0;
            2: return (cyc % 3) != 0;
            3: return ((cyc * 7) % 5) != 0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check_beat(input int k, input string ptag);
        int r = k % H;
        int c = k / H;
        bit ins = (r >= 4) && (c >= 4);
        int e0 = 0, e1 = 0, e2 = 0;
        check(int'(o_row) == r, ptag, int'(o_row), r);
        check(int'(o_col) == c, ptag, int'(o_col), c);
        check(o_inside == ins, "R7 inside flag", int'(o_inside), int'(ins));
        if (ins) begin
            e0 = gauss(1, r, c) - gauss(0, r, c);
            e1 = gauss(2, r, c) - gauss(1, r, c);
            e2 = gauss(3, r, c) - gauss(2, r, c);
            check(int'(o_dog0) == e0, "R5 R6 dog0", int'(o_dog0), e0);
            check(int'(o_dog1) == e1, "R5 R6 dog1", int'(o_dog1), e1);
            check(int'(o_dog2) == e2, "R5 R6 dog2", int'(o_dog2), e2);
        end else begin
            check(o_dog0 == 0 && o_dog1 == 0 && o_dog2 == 0, "R7 border dogs zero",
                  int'(o_dog0) + int'(o_dog1) + int'(o_dog2), 0);
        end
    endtask

    task automatic drive(input int npix, input bit use_sof, input int mode);
        for (int k = 0; k < npix; k++) begin
            @(negedge clk);
            if (mode == 2 && k % 4 == 3) begin
                i_valid = 1'b0;
                @(negedge clk);
            end
            i_valid = 1'b1;
            i_pix   = 8'(frame[k % H][k / H]);
            i_sof   = use_sof && (k == 0);
            while (!i_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        i_valid = 1'b0;
        i_sof   = 1'b0;
    endtask

    task automatic monitor(input int npix, input int mode, input string ptag);
        int cyc = 0;
        if (mode == 4) begin
            int accepted = 0;
            bit seen = 1'b0;
            int srow = 0, scol = 0, sdog = 0;
            for (int t = 0; t < 30; t++) begin
                @(negedge clk);
                o_ready = 1'b0;
                if (i_valid && i_ready) accepted++;
                if (o_valid) begin
                    if (seen)
                        check(int'(o_row) == srow && int'(o_col) == scol && int'(o_dog0) == sdog,
                              "R8 held beat stable", int'(o_row), srow);
                    seen = 1'b1;
                    srow = int'(o_row);
                    scol = int'(o_col);
                    sdog = int'(o_dog0);
                end
            end
            check(accepted == DEPTH + 1, "R2 capacity under stall", accepted, DEPTH + 1);
            check(o_valid == 1'b1, "R8 valid held", int'(o_valid), 1);
        end
        for (int b = 0; b < npix; b++) begin
            forever begin
                @(negedge clk);
                o_ready = ready_at(mode, cyc);
                cyc++;
                if (o_valid && o_ready) break;
            end
            check_beat(b, ptag);
        end
    endtask

    task automatic run_frame(input int kind, input int seed, input int mode,
                             input int npix, input bit use_sof, input string ptag);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                frame[r][c] = pix_at(kind, seed, r, c);
        fork
            drive(npix, use_sof, mode);
            monitor(npix, mode, ptag);
        join
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            o_ready = 1'b1;
        end
        check(o_valid == 1'b0, "R9 no extra beat", int'(o_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(o_valid == 1'b0, "R1 o_valid after reset", int'(o_valid), 0);
        check(i_ready == 1'b1, "R1 i_ready after reset", int'(i_ready), 1);

        foreach (CASES[n]) begin
            run_frame(CASES[n][0], CASES[n][1], CASES[n][2], NPIX, CASES[n][3] != 0,
                      "R3 position");
        end

        // R4: abandoned partial frame, then a fresh frame marked with start-of-frame
        run_frame(0, 17, 0, 10, 1'b1, "R3 partial position");
        run_frame(3, 55, 1, NPIX, 1'b1, "R4 sof restart");

        // R1: reset with data in flight
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                frame[r][c] = pix_at(0, 1, r, c);
        @(negedge clk);
        o_ready = 1'b0;
        i_valid = 1'b1;
        i_pix   = 8'd77;
        repeat (5) @(negedge clk);
        i_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(o_valid == 1'b0, "R1 o_valid after mid-run reset", int'(o_valid), 0);
        check(i_ready == 1'b1, "R1 i_ready after mid-run reset", int'(i_ready), 1);
        run_frame(0, 1, 0, NPIX, 1'b0, "R3 position after reset");

        finish_run();
    end

endmodule